// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes motor-driver settings from a three-wire serial link: a bit clock (`sclk`), a data line (`sdata`) and a latch strobe (`latch`). All three are brought into the `clk` domain through synchronizers and edge detectors. While `latch` is low, each rising `sclk` edge shifts one bit into a 104-bit shift register. Bytes arrive least significant bit first, and the first byte on the wire is byte 0.

The rising edge of `latch` ends the frame. At that edge the block decodes the shift register into a staging register, judges whether the frame is intact, and restarts the bit counter. The falling edge of `latch` commits the result. A good frame copies the staged settings into the live outputs. A bad frame keeps the old settings and raises `out_kill`, which tells the power stage to hold its outputs low. The `pulse_permit` flag allows pulse generation. It is set only on a good commit and is cleared on every rising edge of `latch`.

Top module: `frame_rx`

## Requirements
- R1: After reset, all live settings are zero, and `csum_ok`, `pulse_permit` and `out_kill` are all low.
- R2: Each byte is sent LSB first, and byte 0 is sent first. The field map is:
  - byte 0: `pwm_div`
  - byte 1: `cur_a`
  - byte 2: `cur_b`
  - byte 3: `pulse_cnt[7:0]`
  - byte 4: `pulse_cnt[15:8]`
  - byte 5 bit 0: `pwr_save`
  - byte 5 bit 1: `drv_en`
  - byte 5 bits 3:2: `exc_mode`
  - bytes 6 to 12: no field. They count only toward the checksum.
- R3: A frame is good when exactly 104 `sclk` rising edges arrived between the previous and the present latch rise, and all 13 bytes sum to 00h modulo 256. When `latch` falls after a good frame, the live settings take the new values and `csum_ok` goes high.
- R4: When `latch` falls after a frame with a non-zero sum, the live settings keep their previous values, `csum_ok` goes low and `out_kill` goes high.
- R5: A frame of 103 or 105 clocks is treated as bad in the same way as R4, even when its bytes sum to zero.
- R6: On the latch fall after a good frame, `pulse_permit` goes high only if the new pulse count is non-zero and the new power-save bit is clear. After a bad frame it stays low.
- R7: `pulse_permit` goes low on every rising edge of `latch`.
- R8: A good frame updates `exc_mode` even when it also sets power-save.
- R9: A good frame that follows a bad one clears `out_kill`.
- R10: `sclk` edges that occur while `latch` is high are ignored: they neither shift data nor count toward the 104 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock (asynchronous) |
| sdata | input | 1 | Serial data, sampled on the rise of `sclk` |
| latch | input | 1 | Frame strobe: the rise ends the frame, the fall commits it |
| pwm_div | output | 8 | Live PWM frequency setting |
| cur_a | output | 8 | Live current level, motor A |
| cur_b | output | 8 | Live current level, motor B |
| pulse_cnt | output | 16 | Live output pulse count |
| exc_mode | output | 2 | Live excitation mode |
| pwr_save | output | 1 | Live power-save request |
| drv_en | output | 1 | Live driver enable |
| csum_ok | output | 1 | The last committed frame was good |
| pulse_permit | output | 1 | Pulse generation allowed |
| out_kill | output | 1 | The last committed frame was bad; hold outputs low |

## Verification
Frames of 103 and 105 clocks whose bytes still sum to zero are sent. A design that checked only the sum would accept them and take on shifted field values. A frame whose checksum byte is off by one checks that the live settings are held and that `out_kill` is raised. A design that committed before judging the frame would show the new values.

Extra `sclk` pulses during the latch-high window catch a counter that keeps running while `latch` is high, which would turn a good frame into an error. The bench samples `pulse_permit` inside every latch-high window. This exposes a flag that is cleared only on the falling edge, and also one that is set despite power-save or a zero pulse count.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  localparam int FR_BYTES = 13;
  localparam int FR_BW    = 8;
  localparam int FR_BITS  = FR_BYTES * FR_BW;

  typedef struct packed {
    logic [7:0]  pwm;
    logic [7:0]  cur_a;
    logic [7:0]  cur_b;
    logic [15:0] pulses;
    logic [1:0]  exc;
    logic        ps;
    logic        en;
  } settings_t;

  // Modulo-256 sum over every byte of the frame
  function automatic logic [FR_BW-1:0] frame_sum(input logic [FR_BITS-1:0] f);
    logic [FR_BW-1:0] acc;
    acc = '0;
    for (int k = 0; k < FR_BYTES; k++) acc = acc + f[k*FR_BW +: FR_BW];
    return acc;
  endfunction

  // Field map of a frame, byte 0 in the low bits
  function automatic settings_t frame_decode(input logic [FR_BITS-1:0] f);
    settings_t s;
    s.pwm    = f[7:0];
    s.cur_a  = f[15:8];
    s.cur_b  = f[23:16];
    s.pulses = f[39:24];
    s.en     = f[41];
    s.ps     = f[40];
    s.exc    = f[43:42];
    return s;
  endfunction
endpackage

// File: rtl/frame_rx_sync.sv
module frame_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign q    = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/frame_rx_shift.sv
module frame_rx_shift #(
  parameter int NBITS = 104,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             take,
  input  logic             restart,
  output logic [NBITS-1:0] frame,
  output logic [CW-1:0]    count
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (take) begin
      frame <= {bit_in, frame[NBITS-1:1]};
      if (count != CMAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        latch,
  output logic [7:0]  pwm_div,
  output logic [7:0]  cur_a,
  output logic [7:0]  cur_b,
  output logic [15:0] pulse_cnt,
  output logic [1:0]  exc_mode,
  output logic        pwr_save,
  output logic        drv_en,
  output logic        csum_ok,
  output logic        pulse_permit,
  output logic        out_kill
);
  localparam int CW = $clog2(FR_BITS + 2);

  logic sclk_q, sclk_rise, sclk_fall;
  logic data_q, data_rise, data_fall;
  logic latch_q, latch_rise, latch_fall;
  logic [FR_BITS-1:0] frame;
  logic [CW-1:0]      count;
  logic               frame_good;
  logic               shift_en;
  settings_t          stage, live;
  logic               stage_ok;

  frame_rx_sync #(.STAGES(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk),
    .q(sclk_q), .rise(sclk_rise), .fall(sclk_fall));
  frame_rx_sync #(.STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rst_n(rst_n), .d(sdata),
    .q(data_q), .rise(data_rise), .fall(data_fall));
  frame_rx_sync #(.STAGES(SYNC_STAGES)) u_latch (
    .clk(clk), .rst_n(rst_n), .d(latch),
    .q(latch_q), .rise(latch_rise), .fall(latch_fall));

  assign shift_en = sclk_rise & ~latch_q;

  frame_rx_shift #(.NBITS(FR_BITS), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(data_q), .take(shift_en),
    .restart(latch_rise), .frame(frame), .count(count));

  assign frame_good = (count == CW'(FR_BITS)) && (frame_sum(frame) == '0);

  // Staging: captured when the latch rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= '0;
      stage_ok <= 1'b0;
    end else if (latch_rise) begin
      stage    <= frame_decode(frame);
      stage_ok <= frame_good;
    end
  end

  // Commit: applied when the latch falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live         <= '0;
      csum_ok      <= 1'b0;
      out_kill     <= 1'b0;
      pulse_permit <= 1'b0;
    end else if (latch_fall) begin
      if (stage_ok) begin
        live         <= stage;
        csum_ok      <= 1'b1;
        out_kill     <= 1'b0;
        pulse_permit <= (stage.pulses != '0) && !stage.ps;
      end else begin
        csum_ok      <= 1'b0;
        out_kill     <= 1'b1;
        pulse_permit <= 1'b0;
      end
    end else if (latch_rise) begin
      pulse_permit <= 1'b0;
    end
  end

  assign pwm_div   = live.pwm;
  assign cur_a     = live.cur_a;
  assign cur_b     = live.cur_b;
  assign pulse_cnt = live.pulses;
  assign exc_mode  = live.exc;
  assign pwr_save  = live.ps;
  assign drv_en    = live.en;
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        latch_rise,
  input logic        latch_fall,
  input logic        stage_ok,
  input logic [7:0]  pwm_div,
  input logic [15:0] pulse_cnt,
  input logic        pwr_save,
  input logic        csum_ok,
  input logic        pulse_permit,
  input logic        out_kill
);
  // R7
  permit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rise |=> !pulse_permit);

  // R4
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_fall && !stage_ok) |=> ($stable(pulse_cnt) && $stable(pwm_div) && !csum_ok && out_kill));

  // R3
  good_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_fall && stage_ok) |=> (csum_ok && !out_kill));

  // R6
  permit_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_permit |-> (csum_ok && !pwr_save && pulse_cnt != 16'd0));

  // R3
  live_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fall |=> ($stable(pwm_div) && $stable(pulse_cnt)));
endmodule

bind frame_rx frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .latch_rise(latch_rise), .latch_fall(latch_fall),
  .stage_ok(stage_ok), .pwm_div(pwm_div), .pulse_cnt(pulse_cnt),
  .pwr_save(pwr_save), .csum_ok(csum_ok), .pulse_permit(pulse_permit),
  .out_kill(out_kill));

// File: tb/sim_frame_rx.sv
module sim_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0;
  logic [7:0] pwm_div, cur_a, cur_b;
  logic [15:0] pulse_cnt;
  logic [1:0] exc_mode;
  logic pwr_save, drv_en, csum_ok, pulse_permit, out_kill;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_rx u0 (.*);

  // Entry: pwm, cur_a, cur_b, pulses[16], ctrl, nbits, corrupt
  localparam int NV = 7;
  localparam logic [63:0] VEC [NV] = '{
    {8'd20, 8'd40, 8'd60, 16'h0123, 8'h06, 8'd104, 8'd0},
    {8'd11, 8'd22, 8'd33, 16'h0050, 8'h09, 8'd104, 8'd0},
    {8'd77, 8'd78, 8'd79, 16'h0404, 8'h02, 8'd104, 8'd1},
    {8'd30, 8'd31, 8'd32, 16'h0000, 8'h02, 8'd104, 8'd0},
    {8'd99, 8'd98, 8'd97, 16'h0011, 8'h02, 8'd103, 8'd0},
    {8'd55, 8'd56, 8'd57, 16'h0022, 8'h02, 8'd105, 8'd0},
    {8'd1,  8'd2,  8'd3,  16'hFFFF, 8'h0E, 8'd104, 8'd0}
  };

  logic [7:0] m_pwm, m_ca, m_cb; logic [15:0] m_pul; logic [1:0] m_exc;
  logic m_ps, m_en, m_ok, m_perm, m_kill;

  task automatic chk(input bit cond, input string tag, input int act, input int exp_v);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [103:0] build(input logic [63:0] v);
    logic [7:0] b [13];
    logic [7:0] s;
    logic [103:0] f;
    b[0] = v[63:56]; b[1] = v[55:48]; b[2] = v[47:40];
    b[3] = v[31:24]; b[4] = v[39:32]; b[5] = v[23:16];
    for (int k = 6; k < 12; k++) b[k] = 8'h3C + 8'(k);
    s = 8'h00;
    for (int k = 0; k < 12; k++) s = s + b[k];
    b[12] = 8'h00 - s + v[7:0];
    for (int k = 0; k < 13; k++) f[k*8 +: 8] = b[k];
    return f;
  endfunction

  task automatic send(input logic [103:0] f, input int nbits, input int extra);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 104) ? f[i] : 1'b1;
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(4);
    latch = 1'b1;
    wclk(4);
    for (int i = 0; i < extra; i++) begin
      sdata = 1'b1; sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
    end
    wclk(6);
    chk(pulse_permit == 1'b0, "R7 permit low in latch window", pulse_permit, 0);
    latch = 1'b0;
    wclk(10);
  endtask

  task automatic compare(input string tag);
    chk(csum_ok == m_ok, {tag, " csum_ok"}, csum_ok, m_ok);
    chk(out_kill == m_kill, {tag, " out_kill"}, out_kill, m_kill);
    chk(pulse_permit == m_perm, {tag, " pulse_permit"}, pulse_permit, m_perm);
    chk({pwm_div, cur_a, cur_b} == {m_pwm, m_ca, m_cb}, {tag, " pwm/cur"},
        {pwm_div, cur_a, cur_b}, {m_pwm, m_ca, m_cb});
    chk(pulse_cnt == m_pul, {tag, " pulse_cnt"}, pulse_cnt, m_pul);
    chk({exc_mode, pwr_save, drv_en} == {m_exc, m_ps, m_en}, {tag, " ctrl"},
        {exc_mode, pwr_save, drv_en}, {m_exc, m_ps, m_en});
  endtask

  initial begin
    wclk(200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    {m_pwm, m_ca, m_cb, m_pul, m_exc, m_ps, m_en, m_ok, m_perm, m_kill} = '0;
    wclk(3);
    // R1 reset state
    compare("R1 reset");
    rst_n = 1'b1;
    wclk(3);
    compare("R1 after release");

    // R2 R3 R4 R5 R6 R8 R9: table walk
    for (int v = 0; v < NV; v++) begin
      logic [63:0] e;
      bit good;
      e = VEC[v];
      good = (e[7:0] == 0) && (e[15:8] == 104);
      send(build(e), int'(e[15:8]), 0);
      if (good) begin
        m_pwm = e[63:56]; m_ca = e[55:48]; m_cb = e[47:40]; m_pul = e[39:24];
        m_ps = e[16]; m_en = e[17]; m_exc = e[19:18];
        m_ok = 1'b1; m_kill = 1'b0;
        m_perm = (m_pul != 0) && !m_ps;
      end else begin
        m_ok = 1'b0; m_kill = 1'b1; m_perm = 1'b0;
      end
      compare($sformatf("R2/R3/R4/R5/R6/R8/R9 vec%0d", v));
    end

    // R10: sclk pulses while latch is high must not spoil a good frame
    send(build({8'd5, 8'd6, 8'd7, 16'h0009, 8'h06, 8'd104, 8'd0}), 104, 5);
    m_pwm = 8'd5; m_ca = 8'd6; m_cb = 8'd7; m_pul = 16'h0009;
    m_ps = 1'b0; m_en = 1'b1; m_exc = 2'd1; m_ok = 1'b1; m_kill = 1'b0; m_perm = 1'b1;
    compare("R10 latch-high clocks");

    // R8: power-save frame still changes exc_mode
    send(build({8'd5, 8'd6, 8'd7, 16'h0009, 8'h0D, 8'd104, 8'd0}), 104, 0);
    chk(exc_mode == 2'd3, "R8 exc under power-save", exc_mode, 3);
    chk(pulse_permit == 1'b0, "R6 permit blocked by power-save", pulse_permit, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule